// File: doc/BRIEF.md
# Paging access rights checker

This block decides whether one memory access may proceed once its address has been translated. It takes the kind of access (data read, data write or instruction fetch), the current privilege level, the global protection controls, and the attribute bits of every paging-structure entry that took part in the translation. From these it produces an allow/fault decision. On a fault it also gives the page-fault vector and an error code that describes the fault.

The attribute bits are combined across entries in two ways. The user, writable and execute-disable rules need a bit to agree in every entry. The supervisor-execute guard is met when at least one entry marks the page as supervisor. The decision is combinational from the inputs. The only stored state is the supervisor-execute guard control bit. A write to that bit takes effect on the next clock edge, and reset clears it.

Top module: `apr_access_check`

## Requirements
- R1: Privilege levels 0, 1 and 2 count as supervisor. Level 3 counts as user. Error code bit 2 is 1 on a fault taken in user mode.
- R2: If the present bit is 0 in any entry, the access faults with error code bit 0 cleared, whatever the rights bits say. A fault with every entry present sets error code bit 0.
- R3: A user-mode access of any kind faults unless the user bit is 1 in every entry.
- R4: A user-mode write faults unless the writable bit is 1 in every entry.
- R5: A supervisor write with `wp` = 0 is allowed whatever the writable bits are. With `wp` = 1 it faults unless every entry is writable.
- R6: With the guard bit at 0, a supervisor fetch is limited only by R7. With the guard bit at 1, a supervisor fetch faults unless at least one entry has its user bit at 0.
- R7: When `pae_en` and `nx_en` are both 1, any fetch faults if the execute-disable bit is 1 in any entry. Otherwise the execute-disable bits have no effect.
- R8: The guard bit is 0 after reset. With `guard_we` = 1 at a rising edge, it takes the value of `guard_wdata` from the next cycle on.
- R9: Error code bit 1 is 1 for a faulting write. Bit 4 is 1 for a faulting fetch while the guard bit is 1 or execute-disable is active. Bit 3 is 0. The whole error code is 0 when the access is allowed.
- R10: `fault` is always the inverse of `allow`. `fault_vector` is 14 on a fault and 0 otherwise.
- R11: Access type encoding: 0 is data read, 1 is data write, 2 is instruction fetch, and 3 is treated as a data read. A supervisor read of a present page is always allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the guard control register |
| rst_n | input | 1 | Active-low reset; clears the guard bit |
| guard_we | input | 1 | Write enable for the guard bit |
| guard_wdata | input | 1 | New guard bit value |
| acc_type | input | 2 | Access kind (encoding in R11) |
| cpl | input | 2 | Current privilege level |
| wp | input | 1 | Write protect for supervisor writes |
| nx_en | input | 1 | No-execute enable |
| pae_en | input | 1 | Extended (64-bit entry) paging mode |
| ent_present | input | LEVELS | Present bit per controlling entry |
| ent_writable | input | LEVELS | Writable bit per entry |
| ent_user | input | LEVELS | User-accessible bit per entry |
| ent_xd | input | LEVELS | Execute-disable bit per entry |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Access raises a page fault |
| fault_vector | output | 8 | 14 on fault, else 0 |
| err_code | output | 5 | Page-fault error code |

## Verification
Apart from the guard bit, the block holds no internal state that could go wrong. A bad guard value shows up only as supervisor fetches of pages that are user in every entry. In the same cycle it flips `allow` for those fetches, and it also changes `err_code` bit 4 on any fetch fault while execute-disable is off. A wrong reduction across entries or a wrong rule shows up at once on the same input vector. For that reason, every combination of access type, privilege, controls and per-entry attributes is applied with the guard both clear and set.

// File: rtl/apr_pkg.sv
package apr_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Summary of the walk, reduced over all controlling entries
  typedef struct packed {
    logic all_present;
    logic all_writable;
    logic all_user;
    logic any_xd;
  } walk_sum_t;

  localparam int unsigned ERR_W = 5;

  function automatic logic is_user_level(input logic [1:0] level);
    return level == 2'd3;
  endfunction

  // Error code layout: [0] protection, [1] write, [2] user, [3] zero, [4] fetch
  function automatic logic [ERR_W-1:0] make_err(input logic faulted,
                                                input logic prot,
                                                input logic wr,
                                                input logic usr,
                                                input logic fetch_tagged);
    logic [ERR_W-1:0] e;
    e = '0;
    if (faulted) begin
      e[0] = prot;
      e[1] = wr;
      e[2] = usr;
      e[4] = fetch_tagged;
    end
    return e;
  endfunction

endpackage

// File: rtl/apr_entry_reduce.sv
module apr_entry_reduce
  import apr_pkg::*;
#(
  parameter int unsigned LEVELS = 2
) (
  input  logic [LEVELS-1:0] present,
  input  logic [LEVELS-1:0] writable,
  input  logic [LEVELS-1:0] user,
  input  logic [LEVELS-1:0] xd,
  output walk_sum_t         sum
);

  logic [LEVELS:0] p_chain, w_chain, u_chain, x_chain;

  assign p_chain[0] = 1'b1;
  assign w_chain[0] = 1'b1;
  assign u_chain[0] = 1'b1;
  assign x_chain[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      assign p_chain[g+1] = p_chain[g] & present[g];
      assign w_chain[g+1] = w_chain[g] & writable[g];
      assign u_chain[g+1] = u_chain[g] & user[g];
      assign x_chain[g+1] = x_chain[g] | xd[g];
    end
  endgenerate

  assign sum.all_present  = p_chain[LEVELS];
  assign sum.all_writable = w_chain[LEVELS];
  assign sum.all_user     = u_chain[LEVELS];
  assign sum.any_xd       = x_chain[LEVELS];

endmodule

// File: rtl/apr_rights.sv
module apr_rights
  import apr_pkg::*;
(
  input  acc_e      acc,
  input  logic      user_mode,
  input  logic      wp,
  input  logic      guard,
  input  logic      xd_active,
  input  walk_sum_t sum,
  output logic      is_write,
  output logic      is_fetch,
  output logic      not_present,
  output logic      user_block,
  output logic      wp_block,
  output logic      xd_block,
  output logic      guard_block,
  output logic      allow
);

  always_comb begin
    is_write    = (acc == ACC_WRITE);
    is_fetch    = (acc == ACC_FETCH);
    not_present = !sum.all_present;
    user_block  = user_mode && (!sum.all_user || (is_write && !sum.all_writable));
    wp_block    = !user_mode && is_write && wp && !sum.all_writable;
    xd_block    = is_fetch && xd_active && sum.any_xd;
    guard_block = is_fetch && !user_mode && guard && sum.all_user;
    allow       = !(not_present || user_block || wp_block || xd_block || guard_block);
  end

endmodule

// File: rtl/apr_errcode.sv
module apr_errcode
  import apr_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned FAULT_VEC = 14
) (
  input  logic             allow,
  input  logic             not_present,
  input  logic             is_write,
  input  logic             is_fetch,
  input  logic             user_mode,
  input  logic             guard,
  input  logic             xd_active,
  output logic [ERR_W-1:0] err,
  output logic [VEC_W-1:0] vec
);

  logic faulted;
  assign faulted = !allow;
  assign err = make_err(faulted, !not_present, is_write, user_mode,
                        is_fetch && (guard || xd_active));
  assign vec = faulted ? VEC_W'(FAULT_VEC) : '0;

endmodule

// File: rtl/apr_access_check.sv
module apr_access_check
  import apr_pkg::*;
#(
  parameter int unsigned LEVELS    = 2,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned FAULT_VEC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_we,
  input  logic              guard_wdata,
  input  logic [1:0]        acc_type,
  input  logic [1:0]        cpl,
  input  logic              wp,
  input  logic              nx_en,
  input  logic              pae_en,
  input  logic [LEVELS-1:0] ent_present,
  input  logic [LEVELS-1:0] ent_writable,
  input  logic [LEVELS-1:0] ent_user,
  input  logic [LEVELS-1:0] ent_xd,
  output logic              allow,
  output logic              fault,
  output logic [VEC_W-1:0]  fault_vector,
  output logic [ERR_W-1:0]  err_code
);

  logic guard_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        guard_q <= 1'b0;
    else if (guard_we) guard_q <= guard_wdata;
  end

  logic      user_mode, xd_active;
  acc_e      acc;
  walk_sum_t sum;
  assign user_mode = is_user_level(cpl);
  assign xd_active = pae_en && nx_en;
  assign acc       = acc_e'(acc_type);

  apr_entry_reduce #(.LEVELS(LEVELS)) u_reduce (
    .present (ent_present),
    .writable(ent_writable),
    .user    (ent_user),
    .xd      (ent_xd),
    .sum     (sum)
  );

  logic is_write, is_fetch, not_present, user_block, wp_block, xd_block, guard_block;
  logic allow_w;

  apr_rights u_rights (
    .acc        (acc),
    .user_mode  (user_mode),
    .wp         (wp),
    .guard      (guard_q),
    .xd_active  (xd_active),
    .sum        (sum),
    .is_write   (is_write),
    .is_fetch   (is_fetch),
    .not_present(not_present),
    .user_block (user_block),
    .wp_block   (wp_block),
    .xd_block   (xd_block),
    .guard_block(guard_block),
    .allow      (allow_w)
  );

  apr_errcode #(.VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_err (
    .allow      (allow_w),
    .not_present(not_present),
    .is_write   (is_write),
    .is_fetch   (is_fetch),
    .user_mode  (user_mode),
    .guard      (guard_q),
    .xd_active  (xd_active),
    .err        (err_code),
    .vec        (fault_vector)
  );

  assign allow = allow_w;
  assign fault = !allow_w;

  // Assertions, next to the logic above
  a_r2_not_present: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ent_present) |-> (fault && !err_code[0]));
  a_r3_user_needs_all_user: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl == 2'd3 && !(&ent_user)) |-> fault);
  a_r4_user_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl == 2'd3 && acc_type == 2'd1 && !(&ent_writable)) |-> fault);
  a_r5_wp_clear_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl != 2'd3 && !wp && acc_type == 2'd1 && (&ent_present)) |-> allow);
  a_r7_xd_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (pae_en && nx_en && acc_type == 2'd2 && (|ent_xd)) |-> fault);
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !guard_q);
  a_r8_guard_write: assert property (@(posedge clk) disable iff (!rst_n)
    guard_we |=> (guard_q == $past(guard_wdata)));
  a_r9_allowed_zero_err: assert property (@(posedge clk) disable iff (!rst_n)
    allow |-> (err_code == '0));
  a_r9_write_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (err_code[1] == (acc_type == 2'd1) && !err_code[3]));
  a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_vector == VEC_W'(FAULT_VEC)));
  a_r11_sup_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl != 2'd3 && (acc_type == 2'd0 || acc_type == 2'd3) && (&ent_present)) |-> allow);

endmodule

// File: tb/tb_apr_access_check.sv
module tb_apr_access_check;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       guard_we = 1'b0, guard_wdata = 1'b0;
  logic [1:0] acc_type = '0, cpl = '0;
  logic       wp = 0, nx_en = 0, pae_en = 0;
  logic [1:0] ent_present = '0, ent_writable = '0, ent_user = '0, ent_xd = '0;
  logic       allow, fault;
  logic [7:0] fault_vector;
  logic [4:0] err_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  apr_access_check dut (
    .clk(clk), .rst_n(rst_n), .guard_we(guard_we), .guard_wdata(guard_wdata),
    .acc_type(acc_type), .cpl(cpl), .wp(wp), .nx_en(nx_en), .pae_en(pae_en),
    .ent_present(ent_present), .ent_writable(ent_writable), .ent_user(ent_user),
    .ent_xd(ent_xd), .allow(allow), .fault(fault), .fault_vector(fault_vector),
    .err_code(err_code)
  );

  // Independent model: walks the entries one by one and returns the first rule broken
  function automatic string model(input bit g, output bit ok, output logic [4:0] ec);
    bit usr, wr, fe, all_p, all_u, all_w, xd_hit, sup_seen;
    string tag;
    usr = (cpl == 3); wr = (acc_type == 1); fe = (acc_type == 2);
    all_p = 1; all_u = 1; all_w = 1; xd_hit = 0; sup_seen = 0;
    for (int i = 0; i < 2; i++) begin
      if (!ent_present[i])  all_p = 0;
      if (!ent_user[i])     begin all_u = 0; sup_seen = 1; end
      if (!ent_writable[i]) all_w = 0;
      if (ent_xd[i] && pae_en && nx_en) xd_hit = 1;
    end
    ok = 1; tag = usr ? "R1" : "R11";
    if (!all_p)                          begin ok = 0; tag = "R2"; end
    else if (usr && !all_u)              begin ok = 0; tag = "R3"; end
    else if (usr && wr && !all_w)        begin ok = 0; tag = "R4"; end
    else if (!usr && wr && wp && !all_w) begin ok = 0; tag = "R5"; end
    else if (fe && xd_hit)               begin ok = 0; tag = "R7"; end
    else if (fe && !usr && g && !sup_seen) begin ok = 0; tag = "R6"; end
    ec = 5'd0;
    if (!ok) begin
      ec[0] = all_p;
      ec[1] = wr;
      ec[2] = usr;
      ec[4] = fe && (g || (pae_en && nx_en));
    end
    return tag;
  endfunction

  task automatic check(input bit g, input string extra);
    bit ok; logic [4:0] ec; string tag;
    tag = model(g, ok, ec);
    n_vec++;
    if (allow !== ok || fault !== !ok) begin
      n_bad++;
      $display("FAIL %s%s allow actual=%b expected=%b (acc=%0d cpl=%0d)", tag, extra, allow, ok, acc_type, cpl);
    end else if (err_code !== ec) begin
      n_bad++;
      $display("FAIL R9 %s err_code actual=%b expected=%b", tag, err_code, ec);
    end else if (fault_vector !== (ok ? 8'd0 : 8'd14)) begin
      n_bad++;
      $display("FAIL R10 fault_vector actual=%0d expected=%0d", fault_vector, ok ? 0 : 14);
    end
  endtask

  task automatic set_guard(input bit v);
    @(negedge clk); guard_we = 1; guard_wdata = v;
    @(negedge clk); guard_we = 0;
  endtask

  // Supervisor fetch of a page marked user in every entry: exposes the guard bit (R8)
  task automatic probe_guard(input bit expect_guard, input string what);
    acc_type = 2; cpl = 0; wp = 0; nx_en = 0; pae_en = 0;
    ent_present = 2'b11; ent_writable = 2'b11; ent_user = 2'b11; ent_xd = 2'b00;
    #1;
    n_vec++;
    if (allow !== !expect_guard) begin
      n_bad++;
      $display("FAIL R8 %s allow actual=%b expected=%b", what, allow, !expect_guard);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    probe_guard(0, "after reset");
    set_guard(1);
    probe_guard(1, "after write 1");
    for (int gi = 0; gi < 2; gi++) begin
      set_guard(gi[0]);
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 8; k++)
            for (int e = 0; e < 256; e++) begin
              acc_type = a[1:0]; cpl = c[1:0];
              {wp, nx_en, pae_en} = k[2:0];
              ent_present  = {e[4], e[0]};
              ent_writable = {e[5], e[1]};
              ent_user     = {e[6], e[2]};
              ent_xd       = {e[7], e[3]};
              #1;
              check(gi[0], "");
              #1;
            end
    end
    // guard still 1; reset mid-run must clear it (R8)
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    probe_guard(0, "after second reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule